// File: doc/BRIEF.md
# Instruction Fetch Address Translator

This block sits between the fetch unit and the instruction cache. It takes each fetch address and returns either a physical address or a fault code, all in the same cycle. The address takes one of four paths:
- A fetch address with bit 0 set runs privileged code, and the address passes straight through.
- A physical-mode fetch passes through unchanged.
- A fetch that falls in the kernel superpage window is mapped directly.
- Any other fetch is checked against the translation-buffer lookup result that the caller supplies.

When a fetch takes an access violation or a page fault, the block records two values on the next clock edge. The first is the faulting fetch address, in a tag register. The second is a formatted address for the miss handler, built from the instruction page-table base and the virtual page number. The buffer itself, refill and data-side checks live elsewhere.

Top module: `itx_fetch_xlate`

## Requirements
- R1: When `req_valid_i` is high and fetch address bit 0 is set, the fault code is 0 (none). The physical address is the fetch address with bits 1:0 cleared and bits 63:44 cleared. The mode, physical-mode and lookup inputs have no effect.
- R2: With bit 0 clear and `phys_mode_i` high, the physical address equals the fetch address. If any of bits 63:44 are set, the fault code is 3 (machine check).
- R3: With bit 0 clear and `phys_mode_i` low, bits 63:42 of the fetch address must all be equal. If they are not, the fault code is 1 (access violation).
- R4: A valid virtual address whose bits 47:41 equal 7'h7e is a superpage fetch. In kernel mode (mode 0), the physical address is the fetch address masked to bits 43:0. If bit 40 is set, bits 43:41 are forced to 1; if bit 40 is clear, bits 43:40 are cleared. The fault code is 0.
- R5: A superpage fetch in any mode other than kernel gives fault code 1.
- R6: A valid, non-superpage fetch with `tlb_hit_i` low gives fault code 2 (page fault).
- R7: On a hit, the block reads bit `mode_i` of `tlb_rd_en_i`, with modes 0 kernel, 1 executive, 2 supervisor and 3 user. If that bit is clear, the fault code is 1.
- R8: A permitted hit gives the physical address `(tlb_ppn_i << 13) + (fetch[12:0] & ~3)`. If any of bits 63:44 of that result are set, the fault code is 3.
- R9: The tag and formatted registers are written only on the clock edge after a valid request whose fault code is 1 or 2. The tag register takes the fetch address. The formatted register takes `ptbr_i | (fetch[42:13] << 3)`. Both registers hold their value after a no-fault request, a machine check or an idle cycle.
- R10: Reset clears both fault registers to zero.
- R11: When `req_valid_i` is low, the fault code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Fetch request present |
| fetch_addr_i | input | 64 | Fetch virtual address |
| phys_mode_i | input | 1 | Treat the address as physical |
| mode_i | input | 2 | Current mode: 0 kernel, 1 executive, 2 supervisor, 3 user |
| tlb_hit_i | input | 1 | Lookup found a matching entry |
| tlb_ppn_i | input | 32 | Physical page number of the entry |
| tlb_rd_en_i | input | 4 | Per-mode read enable of the entry |
| ptbr_i | input | 64 | Instruction page-table base |
| paddr_o | output | 64 | Physical address |
| fault_o | output | 2 | 0 none, 1 access violation, 2 page fault, 3 machine check |
| fault_tag_o | output | 64 | Last faulting fetch address |
| fault_form_o | output | 64 | Last formatted fault address |

## Verification
The register capture of one request and the combinational result of the next request happen in the same cycle. The bench provokes this with back-to-back requests: a fault followed at once by another fault, by a machine check or by a bypass fetch. In each such cycle it checks the current fault code against that request's own path. At the same time it checks that the registers show the previous fault, and only a fault of code 1 or 2.

// File: rtl/itx_pkg.sv
package itx_pkg;
  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_ACV  = 2'd1,
    FLT_PGF  = 2'd2,
    FLT_MCHK = 2'd3
  } itx_fault_e;

  typedef enum logic [1:0] {
    MODE_KERN = 2'd0,
    MODE_EXEC = 2'd1,
    MODE_SUPV = 2'd2,
    MODE_USER = 2'd3
  } itx_mode_e;
endpackage

// File: rtl/itx_va_classify.sv
module itx_va_classify #(
  parameter int ADDR_W = 64,
  parameter int VA_W   = 43,
  parameter int SP_HI  = 47,
  parameter int SP_LO  = 41,
  parameter logic [SP_HI-SP_LO:0] SP_TAG = 7'h7e
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              bypass_o,
  output logic              va_ok_o,
  output logic              superpage_o
);
  localparam int EXT_W = ADDR_W - VA_W + 1;

  logic [EXT_W-1:0] ext_bits;

  assign ext_bits    = addr_i[ADDR_W-1:VA_W-1];
  assign bypass_o    = addr_i[0];
  assign va_ok_o     = (&ext_bits) | ~(|ext_bits);
  assign superpage_o = va_ok_o && (addr_i[SP_HI:SP_LO] == SP_TAG);
endmodule

// File: rtl/itx_perm_check.sv
module itx_perm_check #(
  parameter int ADDR_W     = 64,
  parameter int PPN_W      = 32,
  parameter int PAGE_SHIFT = 13,
  parameter int N_MODE     = 4,
  parameter int MODE_W     = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [PPN_W-1:0]  ppn_i,
  input  logic [N_MODE-1:0] rd_en_i,
  output logic              allow_o,
  output logic [ADDR_W-1:0] paddr_o
);
  logic [N_MODE-1:0] sel;

  for (genvar m = 0; m < N_MODE; m++) begin : g_mode
    assign sel[m] = (mode_i == MODE_W'(m)) && rd_en_i[m];
  end

  assign allow_o = |sel;

  logic [ADDR_W-1:0] page_base;
  logic [ADDR_W-1:0] page_off;

  assign page_base = ADDR_W'(ppn_i) << PAGE_SHIFT;
  assign page_off  = ADDR_W'({addr_i[PAGE_SHIFT-1:2], 2'b00});
  assign paddr_o   = page_base + page_off;
endmodule

// File: rtl/itx_fault_regs.sv
module itx_fault_regs #(
  parameter int ADDR_W = 64,
  parameter int VPN_W  = 30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [VPN_W-1:0]  vpn_i,
  input  logic [ADDR_W-1:0] ptbr_i,
  output logic [ADDR_W-1:0] tag_o,
  output logic [ADDR_W-1:0] form_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_o  <= '0;
      form_o <= '0;
    end else if (capture_i) begin
      tag_o  <= addr_i;
      form_o <= ptbr_i | (ADDR_W'(vpn_i) << 3);
    end
  end

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_i |=> $stable(tag_o) && $stable(form_o));
  p_capture_tag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> tag_o == $past(addr_i));
  p_capture_form_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> (form_o & $past(ptbr_i)) == $past(ptbr_i));
endmodule

// File: rtl/itx_fetch_xlate.sv
module itx_fetch_xlate #(
  parameter int ADDR_W     = 64,
  parameter int VA_W       = 43,
  parameter int PA_W       = 44,
  parameter int PAGE_SHIFT = 13,
  parameter int PPN_W      = 32,
  parameter int SP_FILL    = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [63:0]       fetch_addr_i,
  input  logic              phys_mode_i,
  input  logic [1:0]        mode_i,
  input  logic              tlb_hit_i,
  input  logic [31:0]       tlb_ppn_i,
  input  logic [3:0]        tlb_rd_en_i,
  input  logic [63:0]       ptbr_i,
  output logic [63:0]       paddr_o,
  output logic [1:0]        fault_o,
  output logic [63:0]       fault_tag_o,
  output logic [63:0]       fault_form_o
);
  import itx_pkg::*;

  localparam int VPN_W = VA_W - PAGE_SHIFT;
  localparam logic [ADDR_W-1:0] PA_MASK =
    {{(ADDR_W-PA_W){1'b0}}, {PA_W{1'b1}}};
  localparam logic [ADDR_W-1:0] FILL_MASK =
    {{(ADDR_W-PA_W){1'b0}}, {(PA_W-SP_FILL){1'b1}}, {SP_FILL{1'b0}}};
  localparam logic [ADDR_W-1:0] LOW_MASK =
    {{(ADDR_W-SP_FILL){1'b0}}, {SP_FILL{1'b1}}};

  logic              bypass, va_ok, superpage, allow;
  logic [ADDR_W-1:0] hit_pa, pa;
  itx_fault_e        flt;

  itx_va_classify #(.ADDR_W(ADDR_W), .VA_W(VA_W)) i_classify (
    .addr_i      (fetch_addr_i),
    .bypass_o    (bypass),
    .va_ok_o     (va_ok),
    .superpage_o (superpage)
  );

  itx_perm_check #(.ADDR_W(ADDR_W), .PPN_W(PPN_W), .PAGE_SHIFT(PAGE_SHIFT)) i_perm (
    .addr_i  (fetch_addr_i),
    .mode_i  (mode_i),
    .ppn_i   (tlb_ppn_i),
    .rd_en_i (tlb_rd_en_i),
    .allow_o (allow),
    .paddr_o (hit_pa)
  );

  // priority: bypass, physical, bad VA, superpage, lookup; then range check
  always_comb begin
    pa  = '0;
    flt = FLT_NONE;
    if (bypass) begin
      pa = fetch_addr_i & ~ADDR_W'(3) & PA_MASK;
    end else begin
      if (phys_mode_i) begin
        pa = fetch_addr_i;
      end else if (!va_ok) begin
        flt = FLT_ACV;
      end else if (superpage) begin
        if (mode_i != MODE_KERN) flt = FLT_ACV;
        else if (fetch_addr_i[SP_FILL]) pa = (fetch_addr_i & PA_MASK) | FILL_MASK;
        else pa = fetch_addr_i & LOW_MASK;
      end else if (!tlb_hit_i) begin
        flt = FLT_PGF;
      end else if (!allow) begin
        flt = FLT_ACV;
      end else begin
        pa = hit_pa;
      end
      if (flt == FLT_NONE && (pa & ~PA_MASK) != '0) flt = FLT_MCHK;
    end
    if (!req_valid_i) flt = FLT_NONE;
  end

  assign paddr_o = pa;
  assign fault_o = flt;

  itx_fault_regs #(.ADDR_W(ADDR_W), .VPN_W(VPN_W)) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (flt == FLT_ACV || flt == FLT_PGF),
    .addr_i    (fetch_addr_i),
    .vpn_i     (fetch_addr_i[VA_W-1:PAGE_SHIFT]),
    .ptbr_i    (ptbr_i),
    .tag_o     (fault_tag_o),
    .form_o    (fault_form_o)
  );

  p_bypass_clean_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && fetch_addr_i[0] |-> fault_o == FLT_NONE && paddr_o[1:0] == 2'b00);
  p_pa_in_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && fault_o == FLT_NONE |-> (paddr_o & ~PA_MASK) == '0);
  p_mchk_out_of_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o == FLT_MCHK |-> (paddr_o & ~PA_MASK) != '0);
  p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> fault_o == FLT_NONE);
  p_superpage_user_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !fetch_addr_i[0] && !phys_mode_i && superpage && mode_i != MODE_KERN
    |-> fault_o == FLT_ACV);
endmodule

// File: tb/test_itx_fetch_xlate.sv
module test_itx_fetch_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [63:0] fetch_addr = '0;
  logic        phys_mode = 1'b0;
  logic [1:0]  mode = '0;
  logic        tlb_hit = 1'b0;
  logic [31:0] tlb_ppn = '0;
  logic [3:0]  tlb_rd_en = '0;
  logic [63:0] ptbr = '0;
  logic [63:0] paddr, f_tag, f_form;
  logic [1:0]  fault;

  always #2.5 clk = ~clk;

  itx_fetch_xlate i_itx_fetch_xlate (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .fetch_addr_i(fetch_addr),
    .phys_mode_i(phys_mode), .mode_i(mode), .tlb_hit_i(tlb_hit), .tlb_ppn_i(tlb_ppn),
    .tlb_rd_en_i(tlb_rd_en), .ptbr_i(ptbr), .paddr_o(paddr), .fault_o(fault),
    .fault_tag_o(f_tag), .fault_form_o(f_form)
  );

  typedef struct packed {
    logic [63:0] pa;
    logic [1:0]  flt;
    logic        chk_pa;
    logic [63:0] tag;
    logic [63:0] form;
  } exp_t;

  exp_t  exp_q[$];
  string req_q[$];
  int    n_checks = 0, n_fail = 0;
  bit    done = 1'b0;
  logic [63:0] m_tag = '0, m_form = '0;

  task automatic check64(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // expected behaviour, from the requirements
  task automatic model(input logic [63:0] a, input logic ph, input logic [1:0] md,
                       input logic hit, input logic [31:0] ppn, input logic [3:0] rde,
                       output logic [63:0] pa, output logic [1:0] flt);
    pa = '0; flt = 2'd0;
    if (a[0]) begin
      pa = {20'h0, a[43:2], 2'b00};
      return;
    end
    if (ph) pa = a;
    else if (!(&a[63:42] || !(|a[63:42]))) flt = 2'd1;
    else if (a[47:41] == 7'h7e) begin
      if (md != 2'd0) flt = 2'd1;
      else if (a[40]) pa = {20'h0, 3'b111, a[40:0]};
      else pa = {24'h0, a[39:0]};
    end else if (!hit) flt = 2'd2;
    else if (!rde[md]) flt = 2'd1;
    else pa = ({32'h0, ppn} << 13) + {51'h0, a[12:2], 2'b00};
    if (flt == 2'd0 && pa[63:44] != 0) flt = 2'd3;
  endtask

  task automatic drive(string req, input logic v, input logic [63:0] a, input logic ph,
                       input logic [1:0] md, input logic hit, input logic [31:0] ppn,
                       input logic [3:0] rde, input logic [63:0] base);
    exp_t e;
    logic [63:0] pa;
    logic [1:0]  flt;
    @(negedge clk);
    req_valid = v; fetch_addr = a; phys_mode = ph; mode = md;
    tlb_hit = hit; tlb_ppn = ppn; tlb_rd_en = rde; ptbr = base;
    model(a, ph, md, hit, ppn, rde, pa, flt);
    if (!v) flt = 2'd0;
    e.pa = pa; e.flt = flt;
    e.chk_pa = v && (flt == 2'd0 || flt == 2'd3);
    e.tag = m_tag; e.form = m_form;
    exp_q.push_back(e); req_q.push_back(req);
    if (v && (flt == 2'd1 || flt == 2'd2)) begin
      m_tag  = a;
      m_form = base | ({34'h0, a[42:13]} << 3);
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk); #1;
      if (exp_q.size() > 0) begin
        exp_t  e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        check64(r, "fault", {62'h0, fault}, {62'h0, e.flt});
        if (e.chk_pa) check64(r, "paddr", paddr, e.pa);
        check64({r, "/R9"}, "tag", f_tag, e.tag);
        check64({r, "/R9"}, "form", f_form, e.form);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check64("R10", "tag after reset", f_tag, 64'h0);
    check64("R10", "form after reset", f_form, 64'h0);
    @(negedge clk); rst_n = 1'b1;

    // R1 bypass ignores phys/mode/lookup
    drive("R1", 1, 64'hFFFF_F000_0000_1237, 1, 2'd3, 0, 32'h0, 4'h0, 64'h0);
    drive("R1", 1, 64'h0000_0123_4567_89AB, 0, 2'd2, 0, 32'h0, 4'h0, 64'h0);
    // R2 physical mode
    drive("R2", 1, 64'h0000_0ABC_DEF0_1234, 1, 2'd3, 0, 32'h0, 4'h0, 64'h0);
    drive("R2", 1, 64'h0000_1000_0000_0000, 1, 2'd0, 0, 32'h0, 4'h0, 64'h0);
    // R3 invalid VA, then immediately another fault (back to back)
    drive("R3", 1, 64'h0000_1000_0000_4000, 0, 2'd0, 1, 32'h5, 4'hF, 64'h0000_0002_0000_0000);
    drive("R6", 1, 64'h0000_0000_0012_6000, 0, 2'd1, 0, 32'h0, 4'h0, 64'h0000_0004_0000_0000);
    // machine check right after a fault: regs must hold
    drive("R2", 1, 64'h0000_2000_0000_0000, 1, 2'd0, 0, 32'h0, 4'h0, 64'hFFFF_0000_0000_0000);
    // R4 superpage kernel, both fill polarities
    drive("R4", 1, 64'hFFFF_FD00_0000_2000, 0, 2'd0, 0, 32'h0, 4'h0, 64'h0);
    drive("R4", 1, 64'hFFFF_FC12_3456_7004, 0, 2'd0, 0, 32'h0, 4'h0, 64'h0);
    // R5 superpage in other modes
    drive("R5", 1, 64'hFFFF_FC00_0000_8000, 0, 2'd1, 1, 32'h1, 4'hF, 64'h0000_0008_0000_0000);
    drive("R5", 1, 64'hFFFF_FD00_0010_0000, 0, 2'd3, 1, 32'h1, 4'hF, 64'h0);
    // R7 / R8 per-mode read enable
    for (int m = 0; m < 4; m++) begin
      drive("R8", 1, 64'h0000_0000_0040_1ABE, 0, 2'(m), 1, 32'h0000_1234, 4'(1 << m), 64'h0);
      drive("R7", 1, 64'h0000_0000_0040_1ABC, 0, 2'(m), 1, 32'h0000_1234, ~4'(1 << m), 64'h0000_0010_0000_0000);
    end
    // R8 high page number gives machine check; negative-sign valid VA translates
    drive("R8", 1, 64'h0000_0000_0000_0FF8, 0, 2'd0, 1, 32'hFFFF_FFFF, 4'h1, 64'h0);
    drive("R8", 1, 64'hFFFF_FFFF_FFFF_E010, 0, 2'd3, 1, 32'h7FFF_FFFF, 4'h8, 64'h0);
    // R11 idle: no fault and no capture even with faulting inputs
    drive("R11", 0, 64'h0000_1000_0000_0000, 0, 2'd3, 0, 32'h0, 4'h0, 64'hFFFF_FFFF_FFFF_FFFF);
    drive("R11", 0, 64'h0000_0000_0000_2000, 0, 2'd0, 0, 32'h0, 4'h0, 64'h0);
    // fault then bypass on the next cycle
    drive("R6", 1, 64'hFFFF_FFFF_F000_0000, 0, 2'd2, 0, 32'h0, 4'h0, 64'h0000_0020_0000_0000);
    drive("R1", 1, 64'h0000_0000_0000_0005, 0, 2'd3, 0, 32'h0, 4'h0, 64'h0);
    drive("R9", 0, 64'h0, 0, 2'd0, 0, 32'h0, 4'h0, 64'h0);
    drive("R9", 0, 64'h0, 0, 2'd0, 0, 32'h0, 4'h0, 64'h0);

    while (exp_q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule